// File: doc/BRIEF.md
# Two-Variant Interrupt Aggregator

This block collects up to 32 peripheral interrupt lines and presents a single request to a parent interrupt controller. Each line has a status bit and a mask bit. A line raises the parent request when its status bit is 1 and its mask bit is 0. Software reaches the block through a small word-addressed register bus. The bus has an address, a write enable, write data, and read data that is combinational from the address.

A build-time parameter selects one of two variants.

- **Latched variant:** each status bit is sticky. It is set by a rising edge of its synchronized source. Software can force it with a set register and acknowledges it through a write-one-to-clear register.
- **Level variant:** status mirrors the synchronized source levels. It has no set or clear register, so a pending line goes away only when its source drops.

In both variants the mask is changed through two write-one registers, one that disables lines and one that enables them. This lets a driver change one line without a read-modify-write.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: After synchronous reset, every mask bit reads 1, every status bit reads 0 and `irq_o` is 0.
- R2: Writing 1s to mask-disable sets those mask bits; writing 1s to mask-enable clears them; bits written as 0 keep their value. The register offsets are as follows.
  - Latched variant: mask status 0x0C, mask-disable 0x10, mask-enable 0x14.
  - Level variant: mask status 0x04, mask-disable 0x08, mask-enable 0x0C.
- R3: In the latched variant, a rising edge on a source sets its status bit (read at 0x00), and the bit stays 1 after the source falls.
- R4: In the latched variant, writing 1s to the clear register (0x08) clears those status bits. A rising edge that arrives in the same cycle as the clear keeps the bit at 1.
- R5: In the latched variant, writing 1s to the software-set register (0x04) forces those status bits to 1.
- R6: In the level variant, status (0x00) reads the source levels after the synchronizer. The offsets 0x10 and 0x14 are unmapped, and writes to the status or mask-status offsets change nothing.
- R7: `irq_o` is the OR of status AND NOT mask, registered. It changes one clock after the status or mask change that causes it.
- R8: Reads return 0 at the write-only offsets and at unmapped offsets. Writes to unmapped offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_LINES | Peripheral interrupt sources, asynchronous |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Request to the parent controller |

## Verification
The bench builds two instances side by side. Both use the default 32 lines and two synchronizer stages; one sets LATCHED=1 and the other LATCHED=0. Together they expose both offset maps and both status behaviours under the same source pattern. Directed cases align a clear write exactly with an edge-detect cycle and time the registered request against a mask-enable write. A seeded random mix of source changes and writes, including to read-only and unmapped offsets, is compared against a bench model of status and mask.

// File: rtl/irq_fanin_pkg.sv
package irq_fanin_pkg;

    localparam int OFF_W = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_SWSET,
        SEL_CLEAR,
        SEL_MSTAT,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;

    typedef struct packed {
        logic sw_set;
        logic clear;
        logic mask_set;
        logic mask_clr;
    } wr_strobe_t;

    // Map a byte offset to a register for the chosen variant.
    function automatic reg_sel_e decode_offset(input bit latched, input logic [OFF_W-1:0] off);
        reg_sel_e s;
        s = SEL_NONE;
        if (latched) begin
            case (off)
                16'h0000: s = SEL_STATUS;
                16'h0004: s = SEL_SWSET;
                16'h0008: s = SEL_CLEAR;
                16'h000C: s = SEL_MSTAT;
                16'h0010: s = SEL_MSET;
                16'h0014: s = SEL_MCLR;
                default:  s = SEL_NONE;
            endcase
        end else begin
            case (off)
                16'h0000: s = SEL_STATUS;
                16'h0004: s = SEL_MSTAT;
                16'h0008: s = SEL_MSET;
                16'h000C: s = SEL_MCLR;
                default:  s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_fanin_decode.sv
module irq_fanin_decode
    import irq_fanin_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LATCHED = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output reg_sel_e          sel,
    output wr_strobe_t        wr
);

    logic [OFF_W-1:0] off_ext;

    assign off_ext = OFF_W'(addr);

    always_comb begin
        sel         = decode_offset(LATCHED != 0, off_ext);
        wr.sw_set   = we && (sel == SEL_SWSET);
        wr.clear    = we && (sel == SEL_CLEAR);
        wr.mask_set = we && (sel == SEL_MSET);
        wr.mask_clr = we && (sel == SEL_MCLR);
    end

endmodule

// File: rtl/irq_fanin_status.sv
module irq_fanin_status
    import irq_fanin_pkg::*;
#(
    parameter int N           = 32,
    parameter int SYNC_STAGES = 2,
    parameter int LATCHED     = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  wr_strobe_t   wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [N-1:0] sync_q [SYNC_STAGES];
    logic [N-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= src;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign live = sync_q[LAST];

    generate
        if (LATCHED != 0) begin : g_latched
            logic [N-1:0] prev_q;
            logic [N-1:0] sticky_q;
            logic [N-1:0] rise;
            logic [N-1:0] clr_bits;
            logic [N-1:0] set_bits;

            assign rise     = live & ~prev_q;
            assign clr_bits = wr.clear  ? wdata : '0;
            assign set_bits = wr.sw_set ? wdata : '0;

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q   <= '0;
                    sticky_q <= '0;
                end else begin
                    prev_q   <= live;
                    // new edges and software sets take priority over clear
                    sticky_q <= (sticky_q & ~clr_bits) | rise | set_bits;
                end
            end

            assign status = sticky_q;
        end else begin : g_level
            logic unused_wr;
            assign unused_wr = ^{wr, wdata};
            assign status    = live;
        end
    endgenerate

endmodule

// File: rtl/irq_fanin_mask.sv
module irq_fanin_mask
    import irq_fanin_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_strobe_t   wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask
);

    logic [N-1:0] dis_bits;
    logic [N-1:0] en_bits;

    assign dis_bits = wr.mask_set ? wdata : '0;
    assign en_bits  = wr.mask_clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) mask <= '1;
        else     mask <= (mask | dis_bits) & ~en_bits;
    end

endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl
    import irq_fanin_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LATCHED     = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] src_i,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_o
);

    reg_sel_e             rd_sel;
    wr_strobe_t           wr;
    logic [NUM_LINES-1:0] wdata_lines;
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] mask_q;
    logic                 irq_q;

    assign wdata_lines = bus_wdata[NUM_LINES-1:0];

    irq_fanin_decode #(
        .ADDR_W (ADDR_W),
        .LATCHED(LATCHED)
    ) u_decode (
        .addr(bus_addr),
        .we  (bus_we),
        .sel (rd_sel),
        .wr  (wr)
    );

    irq_fanin_status #(
        .N          (NUM_LINES),
        .SYNC_STAGES(SYNC_STAGES),
        .LATCHED    (LATCHED)
    ) u_status (
        .clk   (clk),
        .rst   (rst),
        .src   (src_i),
        .wr    (wr),
        .wdata (wdata_lines),
        .status(status_q)
    );

    irq_fanin_mask #(
        .N(NUM_LINES)
    ) u_mask (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .wdata(wdata_lines),
        .mask (mask_q)
    );

    always_comb begin
        case (rd_sel)
            SEL_STATUS: bus_rdata = DATA_W'(status_q);
            SEL_MSTAT:  bus_rdata = DATA_W'(mask_q);
            default:    bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(status_q & ~mask_q);
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_fanin_chk.sv
module irq_fanin_chk
    import irq_fanin_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int LATCHED   = 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 irq_o,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] mask_q,
    input reg_sel_e             rd_sel
);

    logic [NUM_LINES-1:0] wd;
    reg_sel_e             wsel;

    assign wd   = bus_wdata[NUM_LINES-1:0];
    assign wsel = decode_offset(LATCHED != 0, OFF_W'(bus_addr));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && status_q == '0 && !irq_o));

    // R2
    mask_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && wsel == SEL_MSET) |=> ((mask_q & $past(wd)) == $past(wd)));

    // R2
    mask_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && wsel == SEL_MCLR) |=> ((mask_q & $past(wd)) == '0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (LATCHED != 0 && !(bus_we && wsel == SEL_CLEAR))
        |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R7
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |=> !irq_o);

    // R8
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == SEL_NONE || rd_sel == SEL_MSET || rd_sel == SEL_MCLR ||
         rd_sel == SEL_SWSET || rd_sel == SEL_CLEAR) |-> (bus_rdata == '0));

endmodule

bind irq_fanin_ctrl irq_fanin_chk #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .LATCHED  (LATCHED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .status_q (status_q),
    .mask_q   (mask_q),
    .rd_sel   (rd_sel)
);

// File: tb/test_irq_fanin_ctrl.sv
module test_irq_fanin_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] src = '0;
    logic [7:0]  a_e = '0, a_v = '0;
    logic        we_e = 1'b0, we_v = 1'b0;
    logic [31:0] wd_e = '0, wd_v = '0;
    logic [31:0] rd_e, rd_v;
    logic        irq_e, irq_v;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_st;      // latched status model
    logic [31:0] m_mk_e;    // latched-variant mask model
    logic [31:0] m_mk_v;    // level-variant mask model

    irq_fanin_ctrl #(.LATCHED(1)) i_irq_fanin_ctrl (
        .clk(clk), .rst(rst), .src_i(src), .bus_addr(a_e), .bus_we(we_e),
        .bus_wdata(wd_e), .bus_rdata(rd_e), .irq_o(irq_e)
    );

    irq_fanin_ctrl #(.LATCHED(0)) i_irq_fanin_ctrl_lvl (
        .clk(clk), .rst(rst), .src_i(src), .bus_addr(a_v), .bus_we(we_v),
        .bus_wdata(wd_v), .bus_rdata(rd_v), .irq_o(irq_v)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] mk);
        return |(st & ~mk);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input bit lvl, input logic [7:0] addr, input logic [31:0] d);
        if (!lvl) begin
            case (addr)
                8'h04: m_st   = m_st | d;
                8'h08: m_st   = m_st & ~d;
                8'h10: m_mk_e = m_mk_e | d;
                8'h14: m_mk_e = m_mk_e & ~d;
                default: ;
            endcase
        end else begin
            case (addr)
                8'h08: m_mk_v = m_mk_v | d;
                8'h0C: m_mk_v = m_mk_v & ~d;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input bit lvl, input logic [7:0] addr, input logic [31:0] d);
        @(negedge clk);
        if (lvl) begin a_v = addr; wd_v = d; we_v = 1'b1; end
        else     begin a_e = addr; wd_e = d; we_e = 1'b1; end
        @(negedge clk);
        we_v = 1'b0;
        we_e = 1'b0;
        model_write(lvl, addr, d);
    endtask

    task automatic rd_chk(input bit lvl, input logic [7:0] addr,
                          input logic [31:0] exp, input string req);
        @(negedge clk);
        if (lvl) a_v = addr; else a_e = addr;
        #1;
        check(req, $sformatf("%s read @%h", lvl ? "level" : "latched", addr),
              lvl ? rd_v : rd_e, exp);
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        m_st = m_st | (v & ~src);
        src  = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic check_all();
        rd_chk(0, 8'h00, m_st,   "R3");
        rd_chk(0, 8'h0C, m_mk_e, "R2");
        rd_chk(1, 8'h00, src,    "R6");
        rd_chk(1, 8'h04, m_mk_v, "R2");
        check("R7", "latched irq_o", {31'b0, irq_e}, {31'b0, exp_irq(m_st, m_mk_e)});
        check("R7", "level irq_o",   {31'b0, irq_v}, {31'b0, exp_irq(src, m_mk_v)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_st   = '0;
        m_mk_e = '1;
        m_mk_v = '1;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(0, 8'h0C, 32'hFFFF_FFFF, "R1");
        rd_chk(1, 8'h04, 32'hFFFF_FFFF, "R1");
        rd_chk(0, 8'h00, 32'h0, "R1");
        check("R1", "latched irq_o", {31'b0, irq_e}, 32'h0);
        check("R1", "level irq_o",   {31'b0, irq_v}, 32'h0);

        // R2 mask enable/disable
        wr(0, 8'h14, 32'h0000_00FF);
        rd_chk(0, 8'h0C, 32'hFFFF_FF00, "R2");
        wr(0, 8'h10, 32'h0000_0003);
        rd_chk(0, 8'h0C, 32'hFFFF_FF03, "R2");
        wr(1, 8'h0C, 32'hF0F0_0000);
        wr(1, 8'h08, 32'h0010_0000);
        rd_chk(1, 8'h04, 32'h0F1F_FFFF, "R2");

        // R3 sticky edge latch, R6 live level
        set_src(32'h0000_0010);
        rd_chk(0, 8'h00, 32'h0000_0010, "R3");
        check("R7", "latched irq after edge", {31'b0, irq_e}, 32'h1);
        rd_chk(1, 8'h00, 32'h0000_0010, "R6");
        check("R7", "level irq masked line", {31'b0, irq_v}, 32'h0);
        set_src(32'h0);
        rd_chk(0, 8'h00, 32'h0000_0010, "R3");
        rd_chk(1, 8'h00, 32'h0, "R6");

        // R4 write-one-to-clear
        wr(0, 8'h08, 32'h0000_0010);
        rd_chk(0, 8'h00, 32'h0, "R4");
        check("R4", "latched irq after clear", {31'b0, irq_e}, 32'h0);

        // R5 software set
        wr(0, 8'h04, 32'h0000_0001);
        rd_chk(0, 8'h00, 32'h0000_0001, "R5");

        // R4 edge coinciding with clear: edge wins
        @(negedge clk);
        src  = 32'h0000_0001;
        m_st = m_st | 32'h1;
        @(negedge clk);
        @(negedge clk);
        a_e = 8'h08; wd_e = 32'h1; we_e = 1'b1;
        @(negedge clk);
        we_e = 1'b0;
        rd_chk(0, 8'h00, 32'h0000_0001, "R4");
        wr(0, 8'h08, 32'h0000_0001);
        rd_chk(0, 8'h00, 32'h0, "R4");
        set_src(32'h0);

        // R5 software set on masked lines
        wr(0, 8'h04, 32'hA000_0000);
        rd_chk(0, 8'h00, 32'hA000_0000, "R5");
        check("R5", "masked soft-set irq", {31'b0, irq_e}, 32'h0);

        // R6 level variant lacks set/clear; read-only offsets ignore writes
        wr(1, 8'h10, 32'hFFFF_FFFF);
        wr(1, 8'h14, 32'hFFFF_FFFF);
        wr(1, 8'h04, 32'h0);
        wr(1, 8'h00, 32'hFFFF_FFFF);
        rd_chk(1, 8'h04, m_mk_v, "R6");
        rd_chk(1, 8'h00, 32'h0, "R6");

        // R8 write-only and unmapped reads, ignored writes
        rd_chk(0, 8'h04, 32'h0, "R8");
        rd_chk(0, 8'h08, 32'h0, "R8");
        rd_chk(0, 8'h10, 32'h0, "R8");
        rd_chk(0, 8'h14, 32'h0, "R8");
        rd_chk(0, 8'h40, 32'h0, "R8");
        rd_chk(1, 8'h08, 32'h0, "R8");
        rd_chk(1, 8'h0C, 32'h0, "R8");
        rd_chk(1, 8'h10, 32'h0, "R8");
        wr(0, 8'h40, 32'hFFFF_FFFF);
        wr(0, 8'h1C, 32'hFFFF_FFFF);
        wr(0, 8'h02, 32'hFFFF_FFFF);
        rd_chk(0, 8'h00, m_st,   "R8");
        rd_chk(0, 8'h0C, m_mk_e, "R8");

        // R7 registered output timing
        wr(0, 8'h08, 32'hFFFF_FFFF);
        wr(0, 8'h04, 32'h0000_0100);
        check("R7", "masked line quiet", {31'b0, irq_e}, 32'h0);
        @(negedge clk);
        a_e = 8'h14; wd_e = 32'h0000_0100; we_e = 1'b1;
        @(negedge clk);
        we_e   = 1'b0;
        m_mk_e = m_mk_e & ~32'h0000_0100;
        check("R7", "irq one cycle after unmask (not yet)", {31'b0, irq_e}, 32'h0);
        @(negedge clk);
        check("R7", "irq after unmask", {31'b0, irq_e}, 32'h1);

        // seeded random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                set_src($urandom);
            end else begin
                wr(0, 8'(($urandom % 8) * 4), $urandom & $urandom);
                wr(1, 8'(($urandom % 6) * 4), $urandom & $urandom);
            end
            check_all();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule